// File: doc/BRIEF.md
# PLL Bring-Up Sequencer

This block walks a clock-generating PLL, together with the output multiplexer of its controller, from whatever condition it powered up in to locked PLL mode. A single-cycle start pulse launches the sequence. The sequence first waits a stabilization interval. It then checks a bypass status input. If the PLL already sits in bypass, the sequencer sets the bandwidth-mode bit, drops the controller onto the bypass clock, asserts bypass and cycles the PLL power-down. If the PLL is not in bypass, the sequencer only moves the controller mux onto the bypass clock.

After that branch, the sequencer loads the multiplier, the pre-divider and a derived bandwidth-adjust value. It runs a divider-update handshake: it polls the busy flag, issues a go pulse, and polls the busy flag again. It then pulses the PLL reset and waits for lock. The lock time is not observed directly; it is modelled as a delay that scales with the pre-divider. Finally the sequencer releases bypass and enables PLL mode. Every wait is a parameter counted in reference-clock cycles, so the microsecond minimums can be set for any reference frequency or shortened for simulation.

A successful run ends with a one-cycle done pulse. A poll that runs out of attempts ends in an error state that holds until the next start pulse.

Top module: `pll_bringup_seq`

## Requirements
- R1: After reset, `pll_en_o`, `bypass_o`, `pwrdn_o`, `pll_rst_o`, `ensat_o`, `upd_go_o`, `done_o` and `err_o` are 0, and `en_src_o` is 1.
- R2: A start pulse seen in idle or error begins a stabilization wait of STAB_CYC cycles. When that wait ends, `pll_en_o` and `en_src_o` are both cleared on the same edge, STAB_CYC cycles after the edge that sampled start.
- R3: When `bypass_stat_i` is 1 at the end of stabilization, `ensat_o` is set together with the mux clear. After SETTLE_CYC cycles `bypass_o` rises. One cycle later `pwrdn_o` rises, and it stays high for exactly PWRDN_CYC cycles, with `bypass_o` high and `pll_en_o` low throughout.
- R4: When `bypass_stat_i` is 0 at the end of stabilization, the run has no power-down pulse and no rise of `bypass_o`, and `ensat_o` keeps its previous value.
- R5: Before the PLL reset pulse, `mult_o` and `prediv_o` take the values of `mult_i` and `prediv_i`, and `bwadj_o` takes the value ((M+1)>>1)-1 for M = `mult_i` >= 1, truncated to BWADJ_W bits. All three hold steady while `pll_rst_o` is high.
- R6: `upd_go_o` is issued as a single one-cycle pulse, and only after `upd_busy_i` has been read as 0. If POLL_LIMIT consecutive polls before the go all read 1, the run ends in error with no go pulse.
- R7: After the go pulse, a busy flag that clears within POLL_LIMIT polls lets the run continue. POLL_LIMIT busy polls end the run in error, and no PLL reset pulse follows.
- R8: Each successful run produces exactly one `pll_rst_o` pulse, exactly RST_CYC cycles long.
- R9: `pll_en_o` rises LOCK_UNIT_CYC*(D+1)+1 cycles after `pll_rst_o` falls, where D = `prediv_i`. `bypass_o` is low on that edge and on the edge before it.
- R10: `done_o` is a one-cycle pulse on the same edge on which `pll_en_o` rises, and it occurs exactly once per successful run.
- R11: `err_o` stays high until a start pulse arrives. It falls on the edge that samples that start.
- R12: A start pulse that arrives while a run is in progress is ignored: the run keeps its timing and gives a single done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock that all waits count |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to run the sequence |
| bypass_stat_i | input | 1 | Current bypass state of the PLL, sampled at the end of stabilization |
| mult_i | input | MULT_W | Multiplier field to program |
| prediv_i | input | PDIV_W | Pre-divider field to program |
| upd_busy_i | input | 1 | Divider-update in progress flag |
| pll_en_o | output | 1 | Controller mux select: 1 = PLL clock |
| en_src_o | output | 1 | Enable-source select for the controller mux |
| bypass_o | output | 1 | PLL bypass control |
| pwrdn_o | output | 1 | PLL power-down control |
| pll_rst_o | output | 1 | PLL reset control |
| ensat_o | output | 1 | Bandwidth-mode (saturation enable) bit |
| mult_o | output | MULT_W | Programmed multiplier |
| prediv_o | output | PDIV_W | Programmed pre-divider |
| bwadj_o | output | BWADJ_W | Programmed bandwidth adjust |
| upd_go_o | output | 1 | One-cycle divider-update go request |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | Sticky poll-timeout error |

## Verification
The assertions assume that `upd_busy_i` behaves like a real divider-update engine: it may be held high, but it does not toggle while the go pulse is itself being issued. They also assume that `mult_i`, `prediv_i` and `bypass_stat_i` do not change during a run. The stimulus sets these inputs only before each start pulse. A bench-side model drives the busy flag, raising it for a chosen number of cycles on each go pulse, or holding it high to force the timeout. The same inputs are kept constant across mid-run start pulses.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_STAB,
    S_SETTLE,
    S_BYPON,
    S_PWRDN,
    S_PROG,
    S_POLL1,
    S_GO,
    S_POLL2,
    S_RST,
    S_LOCK,
    S_BYPOFF,
    S_DONE,
    S_ERR
  } seq_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pll_seq_timer.sv
// Down-counting wait timer: a wait of length N loaded on entry to a state
// reports expiry during the N-th cycle spent in that state.
module pll_seq_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          expired_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i - TW'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - TW'(1);
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/pll_seq_cfg.sv
// Derived programming values: bandwidth adjust from the multiplier and the
// lock wait length from the pre-divider.
module pll_seq_cfg #(
  parameter int MULT_W        = 13,
  parameter int PDIV_W        = 6,
  parameter int BWADJ_W       = 12,
  parameter int LOCK_UNIT_CYC = 500,
  parameter int TW            = 16
) (
  input  logic [MULT_W-1:0]  mult_i,
  input  logic [PDIV_W-1:0]  pdiv_i,
  output logic [BWADJ_W-1:0] bwadj_o,
  output logic [TW-1:0]      lock_len_o
);

  localparam int HW = MULT_W + 1;

  logic [HW-1:0] half;

  always_comb begin
    half       = ({1'b0, mult_i} + HW'(1)) >> 1;
    bwadj_o    = BWADJ_W'(half - HW'(1));
    lock_len_o = TW'(LOCK_UNIT_CYC) * (TW'(pdiv_i) + TW'(1));
  end

endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
  import pll_seq_pkg::*;
#(
  parameter int STAB_CYC      = 10000,
  parameter int SETTLE_CYC    = 4,
  parameter int PWRDN_CYC     = 500,
  parameter int RST_CYC       = 700,
  parameter int LOCK_UNIT_CYC = 500,
  parameter int POLL_LIMIT    = 1000,
  parameter int MULT_W        = 13,
  parameter int PDIV_W        = 6,
  parameter int BWADJ_W       = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               bypass_stat_i,
  input  logic [MULT_W-1:0]  mult_i,
  input  logic [PDIV_W-1:0]  prediv_i,
  input  logic               upd_busy_i,
  output logic               pll_en_o,
  output logic               en_src_o,
  output logic               bypass_o,
  output logic               pwrdn_o,
  output logic               pll_rst_o,
  output logic               ensat_o,
  output logic [MULT_W-1:0]  mult_o,
  output logic [PDIV_W-1:0]  prediv_o,
  output logic [BWADJ_W-1:0] bwadj_o,
  output logic               upd_go_o,
  output logic               done_o,
  output logic               err_o
);

  localparam int unsigned LOCK_MAX = LOCK_UNIT_CYC * (2 ** PDIV_W);
  localparam int unsigned TMAX =
    max2(max2(max2(STAB_CYC, SETTLE_CYC), max2(PWRDN_CYC, RST_CYC)),
         max2(LOCK_MAX, POLL_LIMIT));
  localparam int TW = $clog2(TMAX + 1) + 1;

  seq_state_e state_q, state_d;
  logic          from_byp_q;
  logic          tm_load, tm_done;
  logic [TW-1:0] tm_len, lock_len;
  logic [BWADJ_W-1:0] bw_calc;

  logic               pll_en_q, en_src_q, bypass_q, pwrdn_q, pll_rst_q, ensat_q;
  logic               go_q, done_q, err_q;
  logic [MULT_W-1:0]  mult_q;
  logic [PDIV_W-1:0]  pdiv_q;
  logic [BWADJ_W-1:0] bwadj_q;

  pll_seq_cfg #(
    .MULT_W(MULT_W), .PDIV_W(PDIV_W), .BWADJ_W(BWADJ_W),
    .LOCK_UNIT_CYC(LOCK_UNIT_CYC), .TW(TW)
  ) u_cfg (
    .mult_i    (mult_i),
    .pdiv_i    (pdiv_q),
    .bwadj_o   (bw_calc),
    .lock_len_o(lock_len)
  );

  pll_seq_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load_i   (tm_load),
    .len_i    (tm_len),
    .expired_o(tm_done)
  );

  // Next-state decision
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE, S_ERR: if (start_i) state_d = S_STAB;
      S_STAB:        if (tm_done) state_d = S_SETTLE;
      S_SETTLE:      if (tm_done) state_d = from_byp_q ? S_BYPON : S_PROG;
      S_BYPON:       state_d = S_PWRDN;
      S_PWRDN:       if (tm_done) state_d = S_PROG;
      S_PROG:        state_d = S_POLL1;
      S_POLL1: begin
        if (!upd_busy_i)  state_d = S_GO;
        else if (tm_done) state_d = S_ERR;
      end
      S_GO:          state_d = S_POLL2;
      S_POLL2: begin
        if (!upd_busy_i)  state_d = S_RST;
        else if (tm_done) state_d = S_ERR;
      end
      S_RST:         if (tm_done) state_d = S_LOCK;
      S_LOCK:        if (tm_done) state_d = S_BYPOFF;
      S_BYPOFF:      state_d = S_DONE;
      S_DONE:        state_d = S_IDLE;
      default:       state_d = S_IDLE;
    endcase
  end

  // Wait length for the state being entered
  always_comb begin
    tm_load = (state_d != state_q);
    unique case (state_d)
      S_STAB:         tm_len = TW'(STAB_CYC);
      S_SETTLE:       tm_len = TW'(SETTLE_CYC);
      S_PWRDN:        tm_len = TW'(PWRDN_CYC);
      S_POLL1,
      S_POLL2:        tm_len = TW'(POLL_LIMIT);
      S_RST:          tm_len = TW'(RST_CYC);
      S_LOCK:         tm_len = lock_len;
      default:        tm_len = TW'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      from_byp_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_STAB && state_d == S_SETTLE) from_byp_q <= bypass_stat_i;
    end
  end

  // Registered controls, updated on entry to the state that owns them
  always_ff @(posedge clk) begin
    if (rst) begin
      pll_en_q  <= 1'b0;
      en_src_q  <= 1'b1;
      bypass_q  <= 1'b0;
      pwrdn_q   <= 1'b0;
      pll_rst_q <= 1'b0;
      ensat_q   <= 1'b0;
      go_q      <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      mult_q    <= '0;
      pdiv_q    <= '0;
      bwadj_q   <= '0;
    end else begin
      pwrdn_q   <= (state_d == S_PWRDN);
      pll_rst_q <= (state_d == S_RST);
      go_q      <= (state_d == S_GO);
      done_q    <= (state_d == S_DONE);
      err_q     <= (state_d == S_ERR);
      if (state_q == S_STAB && state_d == S_SETTLE) begin
        pll_en_q <= 1'b0;
        en_src_q <= 1'b0;
        if (bypass_stat_i) ensat_q <= 1'b1;
      end
      if (state_d == S_BYPON)  bypass_q <= 1'b1;
      if (state_d == S_BYPOFF) bypass_q <= 1'b0;
      if (state_d == S_DONE)   pll_en_q <= 1'b1;
      if (state_d == S_PROG) begin
        mult_q  <= mult_i;
        pdiv_q  <= prediv_i;
        bwadj_q <= bw_calc;
      end
    end
  end

  assign pll_en_o  = pll_en_q;
  assign en_src_o  = en_src_q;
  assign bypass_o  = bypass_q;
  assign pwrdn_o   = pwrdn_q;
  assign pll_rst_o = pll_rst_q;
  assign ensat_o   = ensat_q;
  assign mult_o    = mult_q;
  assign prediv_o  = pdiv_q;
  assign bwadj_o   = bwadj_q;
  assign upd_go_o  = go_q;
  assign done_o    = done_q;
  assign err_o     = err_q;

endmodule

// File: rtl/pll_bringup_seq_chk.sv
module pll_bringup_seq_chk #(
  parameter int PWRDN_CYC = 500,
  parameter int RST_CYC   = 700,
  parameter int MULT_W    = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              pll_en_o,
  input logic              bypass_o,
  input logic              pwrdn_o,
  input logic              pll_rst_o,
  input logic              upd_go_o,
  input logic              done_o,
  input logic              err_o,
  input logic [MULT_W-1:0] mult_o
);

  int unsigned pd_cnt, rs_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_cnt <= 0;
      rs_cnt <= 0;
    end else begin
      pd_cnt <= pwrdn_o   ? pd_cnt + 1 : 0;
      rs_cnt <= pll_rst_o ? rs_cnt + 1 : 0;
    end
  end

  p_pwrdn_len_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(pwrdn_o) |-> pd_cnt == PWRDN_CYC);

  p_pwrdn_ctx_r3: assert property (@(posedge clk) disable iff (rst)
    pwrdn_o |-> (bypass_o && !pll_en_o));

  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (pll_rst_o && $past(pll_rst_o)) |-> $stable(mult_o));

  p_go_single_r6: assert property (@(posedge clk) disable iff (rst)
    upd_go_o |=> !upd_go_o);

  p_rst_len_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_rst_o) |-> rs_cnt == RST_CYC);

  p_en_order_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_en_o) |-> (!bypass_o && $past(!bypass_o)));

  p_done_with_en_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_en_o) |-> done_o);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (err_o && !start_i) |=> err_o);

endmodule

bind pll_bringup_seq pll_bringup_seq_chk #(
  .PWRDN_CYC(PWRDN_CYC), .RST_CYC(RST_CYC), .MULT_W(MULT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .pll_en_o (pll_en_o),
  .bypass_o (bypass_o),
  .pwrdn_o  (pwrdn_o),
  .pll_rst_o(pll_rst_o),
  .upd_go_o (upd_go_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .mult_o   (mult_o)
);

// File: tb/pll_bringup_seq_bench.sv
module pll_bringup_seq_bench;

  localparam int STAB = 6, SETL = 4, PDN = 5, RSTC = 7, LU = 3, PL = 8;
  localparam int MW = 13, DW = 6, BW = 12;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, byp_stat = 1'b0, busy = 1'b0;
  logic [MW-1:0] mult = '0;
  logic [DW-1:0] pdiv = '0;
  logic pll_en, en_src, bypass, pwrdn, pll_rst, ensat, go, done, err;
  logic [MW-1:0] mult_o;
  logic [DW-1:0] pdiv_o;
  logic [BW-1:0] bwadj;

  always #2 clk = ~clk;

  pll_bringup_seq #(
    .STAB_CYC(STAB), .SETTLE_CYC(SETL), .PWRDN_CYC(PDN), .RST_CYC(RSTC),
    .LOCK_UNIT_CYC(LU), .POLL_LIMIT(PL), .MULT_W(MW), .PDIV_W(DW), .BWADJ_W(BW)
  ) u_pll_bringup_seq (
    .clk(clk), .rst(rst), .start_i(start), .bypass_stat_i(byp_stat),
    .mult_i(mult), .prediv_i(pdiv), .upd_busy_i(busy),
    .pll_en_o(pll_en), .en_src_o(en_src), .bypass_o(bypass), .pwrdn_o(pwrdn),
    .pll_rst_o(pll_rst), .ensat_o(ensat), .mult_o(mult_o), .prediv_o(pdiv_o),
    .bwadj_o(bwadj), .upd_go_o(go), .done_o(done), .err_o(err)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int t_start, t_mux, t_byp_rise, t_byp_fall, t_pd_rise, t_pd_fall;
  int t_rst_rise, t_rst_fall, t_en_rise, t_done, t_err_rise, t_err_fall;
  int n_go, n_done, n_pd, n_rst, n_byp_rise;
  int b_cur = 2, bcnt = 0;
  bit stuck = 1'b0, pre_vis;
  bit p_en, p_src, p_byp, p_pd, p_rst, p_err;

  always @(posedge clk) cyc <= cyc + 1;

  // Divider-update engine model: busy for b_cur cycles after each go
  always @(negedge clk) begin
    if (go) bcnt = b_cur;
    else if (bcnt > 0) bcnt = bcnt - 1;
    busy = stuck || (bcnt > 0);
  end

  // Event monitor
  always @(negedge clk) begin
    if (((p_en && !pll_en) || (p_src && !en_src)) && t_mux < 0) t_mux = cyc;
    if (!p_byp && bypass) begin t_byp_rise = cyc; n_byp_rise++; end
    if (p_byp && !bypass) t_byp_fall = cyc;
    if (!p_pd && pwrdn) begin t_pd_rise = cyc; n_pd++; end
    if (p_pd && !pwrdn) t_pd_fall = cyc;
    if (!p_rst && pll_rst) begin t_rst_rise = cyc; n_rst++; end
    if (p_rst && !pll_rst) t_rst_fall = cyc;
    if (!p_en && pll_en) t_en_rise = cyc;
    if (done) begin n_done++; t_done = cyc; end
    if (go) n_go++;
    if (!p_err && err) t_err_rise = cyc;
    if (p_err && !err) t_err_fall = cyc;
    p_en = pll_en; p_src = en_src; p_byp = bypass; p_pd = pwrdn;
    p_rst = pll_rst; p_err = err;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    t_mux = -1; t_byp_rise = -1; t_byp_fall = -1; t_pd_rise = -1; t_pd_fall = -1;
    t_rst_rise = -1; t_rst_fall = -1; t_en_rise = -1; t_done = -1;
    t_err_rise = -1; t_err_fall = -1;
    n_go = 0; n_done = 0; n_pd = 0; n_rst = 0; n_byp_rise = 0;
  endtask

  task automatic run(input bit byp, input int m, input int d, input int b,
                     input bit stk, input int extra);
    int w;
    mult = MW'(m); pdiv = DW'(d); byp_stat = byp; b_cur = b; stuck = stk;
    @(posedge clk);
    clear_mon();
    @(negedge clk);
    pre_vis = pll_en || en_src;
    start = 1'b1; t_start = cyc;
    @(negedge clk);
    start = 1'b0;
    if (extra > 0) begin
      repeat (extra) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (n_done == 0 && t_err_rise < 0 && w < 5000) begin
      @(negedge clk);
      w++;
    end
    repeat (3) @(negedge clk);
    if (w >= 5000) chk("R10 run finished", 0, 1);
  endtask

  task automatic check_ok(input bit byp, input int m, input int d);
    int exp_bw;
    exp_bw = (((m + 1) >> 1) - 1) & ((1 << BW) - 1);
    chk("R10 done count", n_done, 1);
    chk("R10 done with enable", t_done, t_en_rise);
    chk("R9 lock wait", t_en_rise - t_rst_fall, LU * (d + 1) + 1);
    chk("R9 final bypass", int'(bypass), 0);
    chk("R9 final enable", int'(pll_en), 1);
    chk("R8 reset pulses", n_rst, 1);
    chk("R8 reset width", t_rst_fall - t_rst_rise, RSTC);
    chk("R5 multiplier", int'(mult_o), m);
    chk("R5 prediv", int'(pdiv_o), d);
    chk("R5 bwadj", int'(bwadj), exp_bw);
    chk("R6 go count", n_go, 1);
    if (pre_vis) chk("R2 stabilization", t_mux - t_start, STAB + 1);
    if (byp) begin
      chk("R9 bypass before enable", t_byp_fall, t_en_rise - 1);
      chk("R3 pwrdn pulses", n_pd, 1);
      chk("R3 pwrdn width", t_pd_fall - t_pd_rise, PDN);
      chk("R3 pwrdn after bypass", t_pd_rise - t_byp_rise, 1);
      chk("R3 ensat", int'(ensat), 1);
      if (pre_vis) chk("R3 settle", t_byp_rise - t_mux, SETL);
    end else begin
      chk("R4 no pwrdn", n_pd, 0);
      chk("R4 no bypass rise", n_byp_rise, 0);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int mlist[10] = '{1, 2, 3, 15, 16, 39, 63, 64, 4095, 8191};
    int dlist[5]  = '{0, 1, 2, 5, 63};
    int dt_ref, k;
    clear_mon();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pll_en", int'(pll_en), 0);
    chk("R1 en_src", int'(en_src), 1);
    chk("R1 bypass", int'(bypass), 0);
    chk("R1 pwrdn", int'(pwrdn), 0);
    chk("R1 pll_rst", int'(pll_rst), 0);
    chk("R1 ensat", int'(ensat), 0);
    chk("R1 go", int'(go), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 err", int'(err), 0);

    // First run without bypass: ensat untouched (R4)
    run(1'b0, 39, 1, 2, 1'b0, 0);
    check_ok(1'b0, 39, 1);
    chk("R4 ensat unchanged", int'(ensat), 0);

    // Sweep multiplier and pre-divider on both paths
    k = 0;
    foreach (dlist[i]) begin
      foreach (mlist[j]) begin
        run(k[0], mlist[j], dlist[i], (k % 4), 1'b0, 0);
        check_ok(k[0], mlist[j], dlist[i]);
        k++;
      end
    end

    // R12 start during a run is ignored
    run(1'b1, 20, 3, 2, 1'b0, 0);
    check_ok(1'b1, 20, 3);
    dt_ref = t_done - t_start;
    run(1'b1, 20, 3, 2, 1'b0, 10);
    chk("R12 timing unchanged", t_done - t_start, dt_ref);
    chk("R12 single done", n_done, 1);

    // R7 post-update poll boundary
    run(1'b0, 24, 0, PL, 1'b0, 0);
    check_ok(1'b0, 24, 0);
    run(1'b0, 24, 0, PL + 1, 1'b0, 0);
    chk("R7 timeout error", int'(err), 1);
    chk("R7 go issued", n_go, 1);
    chk("R7 no reset pulse", n_rst, 0);
    chk("R7 no done", n_done, 0);

    // R11 sticky error, cleared by start
    repeat (20) @(negedge clk);
    chk("R11 error held", int'(err), 1);
    run(1'b0, 19, 0, 1, 1'b0, 0);
    chk("R11 error clears", t_err_fall - t_start, 1);
    chk("R11 recovered", n_done, 1);

    // R6 busy stuck before update
    run(1'b1, 24, 0, 0, 1'b1, 0);
    chk("R6 pre-poll error", int'(err), 1);
    chk("R6 no go", n_go, 0);
    chk("R6 no reset", n_rst, 0);
    run(1'b0, 24, 0, 0, 1'b0, 0);
    chk("R6 recovery done", n_done, 1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule